// File: doc/BRIEF.md
# Debugger-to-core mailbox handshake

This block sits between an external debug port, which it serves as an APB slave, and a processor core. It is a mailbox. A host-to-core data word carries values from the debugger to the core. A core-to-host data word carries values the other way. An instruction word holds the next instruction the debugger wants the core to run. A status word reports the live state of the three handshake flags and the current access mode.

The block keeps two copies of each flag: a live one and a snapshot. Reading the status word copies the live full flags into their snapshots. In nonblocking mode the snapshots decide whether a later data or instruction access takes effect. An access that is refused still completes at once. The debugger can issue several accesses back to back and learn from the next status read which of them landed.

In stall mode a refused access is held with `pready` low until the core side frees it. Fast mode holds accesses in the same way. In fast mode, though, each accepted data transfer also hands the held instruction to the core. On the core side, the core consumes host data, posts outgoing data, receives one-cycle instruction issue pulses, and signals each instruction's completion.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset both full flags are 0, the instruction-done flag is 1, the mode is nonblocking, `issue_vld` is 0, and a status read returns 0x4.
- R2: The address is decoded on `paddr[3:2]` as 0 = status, 1 = host-to-core data (write), 2 = core-to-host data (read), 3 = instruction (write). A status read completes with no wait and returns host-to-core full in bit 0, core-to-host full in bit 1, instruction-done in bit 2 and the mode in bits [5:4]. It also copies both live full flags into their snapshots.
- R3: A status write takes the mode from `pwdata[1:0]`: 00 nonblocking, 01 stall, 10 fast. The value 11 leaves the mode unchanged.
- R4: An accepted host-to-core write stores `pwdata`, sets the live full flag and its snapshot, and presents the word on `core_rx_data` with `core_rx_valid` high.
- R5: A `core_rx_take` pulse clears the live host-to-core full flag. A `core_tx_put` stores `core_tx_data` and sets `core_tx_full` only while `core_tx_full` is 0; otherwise it is ignored.
- R6: An accepted core-to-host read returns the stored word and clears the live flag and its snapshot.
- R7: In nonblocking mode every access completes with no wait. A host-to-core write is ignored while its snapshot is 1. A core-to-host read while its snapshot is 0 returns the current register contents and changes no flag. An instruction write while the instruction-done snapshot is 0 is ignored.
- R8: In stall and fast modes, `pready` is held low while a host-to-core write meets a full flag, while a core-to-host read meets an empty flag, and while an instruction write meets a clear instruction-done flag. The access completes on the first cycle the condition clears.
- R9: An `instr_done` pulse sets instruction-done and its snapshot. An instruction issue clears both.
- R10: In nonblocking and stall modes, an accepted instruction write gives a one-cycle `issue_vld` pulse on the next cycle, with `issue_insn` equal to the written word. In fast mode, an instruction write only loads the word and changes no flag. Each accepted host-to-core write or core-to-host read then issues the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 4 | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready; low stalls the transfer |
| core_rx_data | output | DATA_W | Host-to-core word |
| core_rx_valid | output | 1 | Host-to-core word is full |
| core_rx_take | input | 1 | Core consumes the host-to-core word |
| core_tx_data | input | DATA_W | Word the core posts |
| core_tx_put | input | 1 | Core posts a word |
| core_tx_full | output | 1 | Core-to-host word is full |
| instr_done | input | 1 | Core finished the issued instruction |
| issue_vld | output | 1 | One-cycle instruction issue pulse |
| issue_insn | output | DATA_W | Instruction to execute |

## Verification
The bench targets the snapshot rules. It writes host data twice across a core take without reading status in between; a design that consulted the live flag would accept the second write. It also reads an empty core-to-host word and checks that the flags are untouched, which catches a design that clears state on a refused read. In stall mode it holds each of the three access kinds against the core and checks that a wait occurred. In fast mode it checks that instruction writes do not issue and that data transfers do, since swapping the issue trigger is the most likely fault.

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [3:0]        paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic [DATA_W-1:0] core_rx_data,
  output logic              core_rx_valid,
  input  logic              core_rx_take,
  input  logic [DATA_W-1:0] core_tx_data,
  input  logic              core_tx_put,
  output logic              core_tx_full,
  input  logic              instr_done,
  output logic              issue_vld,
  output logic [DATA_W-1:0] issue_insn
);
  localparam logic [1:0] M_NB = 2'b00, M_STALL = 2'b01, M_FAST = 2'b10;
  localparam logic [1:0] A_STAT = 2'd0, A_RX = 2'd1, A_TX = 2'd2, A_INS = 2'd3;

  logic [1:0]        mode;
  logic              rx_full, rx_snap, tx_full, tx_snap, done, done_snap;
  logic [DATA_W-1:0] rx_data, tx_data, insn;

  wire       acc   = psel & penable;
  wire [1:0] sel   = paddr[3:2];
  wire       st_rd = acc & ~pwrite & (sel == A_STAT);
  wire       st_wr = acc &  pwrite & (sel == A_STAT);
  wire       rx_wr = acc &  pwrite & (sel == A_RX);
  wire       tx_rd = acc & ~pwrite & (sel == A_TX);
  wire       in_wr = acc &  pwrite & (sel == A_INS);
  wire       hold  = (mode == M_STALL) | (mode == M_FAST);
  wire       fast  = (mode == M_FAST);

  wire rx_ok = rx_wr & (hold ? ~rx_full : ~rx_snap);
  wire tx_ok = tx_rd & (hold ?  tx_full :  tx_snap);
  wire in_ok = in_wr & (hold ?  done    :  done_snap);
  wire issue = fast ? (rx_ok | tx_ok) : in_ok;

  assign pready = ~hold | ~((rx_wr & rx_full) | (tx_rd & ~tx_full) | (in_wr & ~done));

  always_comb begin
    prdata = '0;
    if (sel == A_STAT) prdata[5:0] = {mode, 1'b0, done, tx_full, rx_full};
    else if (sel == A_TX) prdata = tx_data;
  end

  assign core_rx_data  = rx_data;
  assign core_rx_valid = rx_full;
  assign core_tx_full  = tx_full;
  assign issue_insn    = insn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_NB;
      rx_full   <= 1'b0;
      rx_snap   <= 1'b0;
      tx_full   <= 1'b0;
      tx_snap   <= 1'b0;
      done      <= 1'b1;
      done_snap <= 1'b1;
      rx_data   <= '0;
      tx_data   <= '0;
      insn      <= '0;
      issue_vld <= 1'b0;
    end else begin
      issue_vld <= issue;
      if (st_rd) begin
        rx_snap <= rx_full;
        tx_snap <= tx_full;
      end
      if (st_wr && pwdata[1:0] != 2'b11) mode <= pwdata[1:0];
      if (core_rx_take) rx_full <= 1'b0;
      if (rx_ok) begin
        rx_data <= pwdata;
        rx_full <= 1'b1;
        rx_snap <= 1'b1;
      end
      if (core_tx_put && !tx_full) begin
        tx_data <= core_tx_data;
        tx_full <= 1'b1;
      end
      if (tx_ok) begin
        tx_full <= 1'b0;
        tx_snap <= 1'b0;
      end
      if (instr_done) begin
        done      <= 1'b1;
        done_snap <= 1'b1;
      end
      if (in_ok) insn <= pwdata;
      if (issue) begin
        done      <= 1'b0;
        done_snap <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbx_checks.sv
module mbx_checks #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [3:0]        paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              pready,
  input logic              issue_vld,
  input logic [DATA_W-1:0] issue_insn,
  input logic [1:0]        mode,
  input logic              rx_full,
  input logic              rx_snap,
  input logic              tx_full,
  input logic              tx_snap,
  input logic              done,
  input logic [DATA_W-1:0] rx_data,
  input logic [DATA_W-1:0] insn
);
  wire acc = psel && penable;

  assert_stall_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && acc && pwrite && paddr[3:2] == 2'd1 && rx_full) |-> !pready);

  assert_rx_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pwrite && paddr[3:2] == 2'd1 && pready && !rx_snap)
      |=> (rx_full && rx_snap && rx_data == $past(pwdata)));

  assert_snap_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pwrite && paddr[3:2] == 2'd0)
      |=> (rx_snap == $past(rx_full) && tx_snap == $past(tx_full)));

  assert_tx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && acc && !pwrite && paddr[3:2] == 2'd2 && pready) |=> (!tx_full && !tx_snap));

  assert_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10 && acc && pwrite && paddr[3:2] == 2'd3 && pready && done)
      |=> (issue_vld && issue_insn == $past(pwdata) && !done));

  assert_nb_insn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && acc && pwrite && paddr[3:2] == 2'd3 && !done)
      |-> ##1 (!issue_vld && $stable(insn)));

  assert_mode_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pwrite && paddr[3:2] == 2'd0 && pwdata[1:0] == 2'b11) |=> $stable(mode));
endmodule

bind dbg_mailbox mbx_checks #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pready(pready), .issue_vld(issue_vld),
  .issue_insn(issue_insn), .mode(mode), .rx_full(rx_full), .rx_snap(rx_snap),
  .tx_full(tx_full), .tx_snap(tx_snap), .done(done), .rx_data(rx_data), .insn(insn)
);

// File: tb/tb_dbg_mailbox.sv
module tb_dbg_mailbox;
  logic        clk = 0, rst_n = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [3:0]  paddr = 0;
  logic [31:0] pwdata = 0, prdata, core_rx_data, core_tx_data = 0, issue_insn;
  logic        pready, core_rx_valid, core_rx_take = 0, core_tx_put = 0, core_tx_full;
  logic        instr_done = 0, issue_vld;
  int          checks = 0, fails = 0, icnt = 0;
  logic [31:0] ilast = 0;

  always #4 clk = ~clk;

  dbg_mailbox dut (.*);

  always @(posedge clk) if (rst_n && issue_vld) begin icnt++; ilast = issue_insn; end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apb(input bit wr, input logic [1:0] sel, input logic [31:0] wd,
                     output logic [31:0] rd, output int waits);
    waits = 0;
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = {sel, 2'b00}; pwdata = wd;
    @(negedge clk);
    penable = 1;
    forever begin
      #2;
      if (pready) begin rd = prdata; @(posedge clk); break; end
      waits++;
      @(negedge clk);
    end
    @(negedge clk);
    psel = 0; penable = 0; paddr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic take();
    @(negedge clk); core_rx_take = 1; @(negedge clk); core_rx_take = 0;
  endtask

  task automatic put(logic [31:0] d);
    @(negedge clk); core_tx_put = 1; core_tx_data = d; @(negedge clk); core_tx_put = 0;
  endtask

  task automatic fin();
    @(negedge clk); instr_done = 1; @(negedge clk); instr_done = 0;
  endtask

  localparam int NV = 16;
  // {op, sel, data, expected}: op 0 apb write, 1 apb read, 2 core put, 3 core take
  localparam logic [67:0] VEC [NV] = '{
    {2'd1, 2'd0, 32'h0, 32'h4},
    {2'd0, 2'd1, 32'h11111111, 32'h0},
    {2'd1, 2'd0, 32'h0, 32'h5},
    {2'd0, 2'd1, 32'h22222222, 32'h0},
    {2'd3, 2'd0, 32'h0, 32'h11111111},
    {2'd0, 2'd1, 32'h33000000, 32'h0},
    {2'd1, 2'd0, 32'h0, 32'h4},
    {2'd0, 2'd1, 32'h33333333, 32'h0},
    {2'd3, 2'd0, 32'h0, 32'h33333333},
    {2'd1, 2'd2, 32'h0, 32'h0},
    {2'd2, 2'd0, 32'hAAAA5555, 32'h0},
    {2'd2, 2'd0, 32'hBBBB0000, 32'h0},
    {2'd1, 2'd2, 32'h0, 32'hAAAA5555},
    {2'd1, 2'd0, 32'h0, 32'h6},
    {2'd1, 2'd2, 32'h0, 32'hAAAA5555},
    {2'd1, 2'd0, 32'h0, 32'h4}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int w;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1 rx_valid", core_rx_valid, 0);
    chk("R1 tx_full", core_tx_full, 0);
    chk("R1 issue_vld", issue_vld, 0);
    chk("R1 status", prdata, 32'h4);

    // vector walk, nonblocking mode: R2 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][67:66])
        2'd0: begin
          apb(1, VEC[i][65:64], VEC[i][63:32], rd, w);
          chk($sformatf("R7 vec%0d no wait", i), w, 0);
        end
        2'd1: begin
          apb(0, VEC[i][65:64], 0, rd, w);
          chk($sformatf("R2 R6 R7 vec%0d read", i), rd, VEC[i][31:0]);
        end
        2'd2: put(VEC[i][63:32]);
        default: begin
          chk($sformatf("R4 R5 vec%0d rx data", i), core_rx_data, VEC[i][31:0]);
          take();
          chk($sformatf("R5 vec%0d take", i), core_rx_valid, 0);
        end
      endcase
    end

    // R3 reserved mode code
    apb(1, 0, 32'h3, rd, w);
    apb(0, 0, 0, rd, w);
    chk("R3 mode 11 kept", rd, 32'h4);

    // R7 R9 R10 nonblocking instruction path
    apb(1, 3, 32'hDEAD0001, rd, w);
    idle(2);
    chk("R10 nb issue count", icnt, 1);
    chk("R10 nb issue word", ilast, 32'hDEAD0001);
    apb(0, 0, 0, rd, w);
    chk("R9 done cleared", rd, 32'h0);
    apb(1, 3, 32'hDEAD0002, rd, w);
    chk("R7 insn no wait", w, 0);
    idle(2);
    chk("R7 insn ignored", icnt, 1);
    fin();
    apb(0, 0, 0, rd, w);
    chk("R9 done set", rd, 32'h4);
    apb(1, 3, 32'hDEAD0003, rd, w);
    idle(2);
    chk("R10 nb issue word 2", ilast, 32'hDEAD0003);

    // R8 stall mode
    apb(1, 0, 32'h1, rd, w);
    apb(0, 0, 0, rd, w);
    chk("R3 stall mode", rd, 32'h10);
    apb(1, 1, 32'h44444444, rd, w);
    chk("R8 free write no wait", w, 0);
    fork
      apb(1, 1, 32'h55555555, rd, w);
      begin idle(6); take(); end
    join
    chk("R8 rx write stalled", w > 0, 1);
    chk("R4 stalled word", core_rx_data, 32'h55555555);
    take();
    fork
      apb(0, 2, 0, rd, w);
      begin idle(5); put(32'h66666666); end
    join
    chk("R8 tx read stalled", w > 0, 1);
    chk("R6 tx read data", rd, 32'h66666666);
    fork
      apb(1, 3, 32'hC0DE0004, rd, w);
      begin idle(4); fin(); end
    join
    chk("R8 insn stalled", w > 0, 1);
    idle(2);
    chk("R10 stall issue", ilast, 32'hC0DE0004);
    chk("R10 stall count", icnt, 3);

    // R10 fast mode
    apb(1, 0, 32'h2, rd, w);
    apb(0, 0, 0, rd, w);
    chk("R3 fast mode", rd, 32'h20);
    fin();
    apb(1, 3, 32'hBEEF0005, rd, w);
    idle(2);
    chk("R10 fast insn no issue", icnt, 3);
    apb(0, 0, 0, rd, w);
    chk("R10 fast insn keeps done", rd, 32'h24);
    apb(1, 1, 32'h77777777, rd, w);
    idle(2);
    chk("R10 fast rx issue count", icnt, 4);
    chk("R10 fast rx issue word", ilast, 32'hBEEF0005);
    apb(0, 0, 0, rd, w);
    chk("R9 fast issue clears done", rd, 32'h21);
    take();
    put(32'h88888888);
    apb(0, 2, 0, rd, w);
    chk("R6 fast tx data", rd, 32'h88888888);
    idle(2);
    chk("R10 fast tx issue count", icnt, 5);
    apb(0, 0, 0, rd, w);
    chk("R2 final status", rd, 32'h20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule